// File: doc/BRIEF.md
# Table-Driven Task Context Restore Sequencer

This block performs the memory side of a task context restore for a small 16-bit processor. A one-cycle start pulse hands it three operands: a 16-bit pointer to a byte holding the task number, a 20-bit base address of a per-task descriptor table, and the current stack pointer. The sequencer reads the task number. It then fetches that task's two-byte descriptor: a selection mask naming which of eight 16-bit registers to reload, and a byte to add to the stack pointer when the restore is finished.

All memory traffic goes through one byte-wide read port with one cycle of read latency. Each selected register is rebuilt from two stack bytes and delivered on a register-write port together with its index. When the last register is written, the new stack pointer is presented on a separate write port in the same cycle as a one-cycle done pulse. The surrounding processor sequences the block and commits both writes.

Top module: `taskctx_restore`

## Requirements
- R1: While reset is held and in the first cycle after it, busy, done, mem_rd_en, reg_we and sp_we are all low.
- R2: The first memory read of an operation is at address {4'h0, tnum_addr}. The byte returned is the task number n, in the range 0 to 255.
- R3: The descriptor address is computed modulo 2^20 as tbl_base + 2*n. The mask is read from that address and the correction byte from the next one, also modulo 2^20. These are the second and third reads.
- R4: Mask bit i selects register index i. Indices 0..3 are R0..R3, 4 is A0, 5 is A1, 6 is SB and 7 is FB. Selected registers are written one per reg_we pulse in strictly ascending index order. Unselected indices are never written.
- R5: Register data comes from ascending stack addresses starting at the stack pointer given at start. Each register takes two consecutive bytes, and the low byte is at the lower address. The stack address is a 16-bit pointer that wraps modulo 2^16, zero-extended to 20 bits.
- R6: After the last register write, sp_we pulses for one cycle with sp_wdata = (sp_in + correction) mod 2^16. done is high in that same cycle.
- R7: A zero mask produces no reg_we pulse. The stack pointer correction is still applied.
- R8: done is a single-cycle pulse. busy is high from the cycle after an accepted start through the done cycle, and no port activity occurs while idle.
- R9: A start pulse while busy is ignored: the running operation's reads and results are unchanged, and no second operation follows.
- R10: With k selected registers, done is high in the cycle that begins at the (4 + 3k)-th rising edge after the edge that samples start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a restore |
| tnum_addr | input | 16 | Address of the byte holding the task number |
| tbl_base | input | 20 | Base address of the task descriptor table |
| sp_in | input | 16 | Stack pointer value at the time of start |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | 20 | Memory read address |
| mem_rdata | input | 8 | Read data, valid the cycle after the request |
| reg_we | output | 1 | Register write strobe |
| reg_sel | output | 3 | Index of the register being written |
| reg_wdata | output | 16 | Restored register value |
| sp_we | output | 1 | Stack pointer write strobe |
| sp_wdata | output | 16 | Corrected stack pointer |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench aims at a zero mask, which a design that always pops at least once would answer with a spurious register write and a late done. It also uses a full mask from a stack pointer a few bytes below 0xFFFF; a design that carries into bit 16 would read the wrong bytes for the upper registers. Task 255 with a table base near the top of the 20-bit space checks the wrap of the descriptor address, where a truncated or unwrapped sum would fetch the wrong mask. A start pulse injected in mid-operation checks that the latched operands hold and that no second run follows. Reversed byte order or reversed register order would show up as data and index mismatches against the bench's own stack walk.

// File: rtl/ctxr_pkg.sv
package ctxr_pkg;
    localparam int ADDR_W = 20;
    localparam int SP_W   = 16;
    localparam int BYTE_W = 8;
    localparam int REG_W  = 2 * BYTE_W;
    localparam int NREG   = 8;
    localparam int IDX_W  = $clog2(NREG);

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_TN,
        S_RD_MASK,
        S_RD_CORR,
        S_GOT_CORR,
        S_POP_LO,
        S_POP_HI,
        S_POP_END,
        S_FIX
    } ctxr_state_e;

    typedef struct packed {
        logic [SP_W-1:0]   tnum_addr;
        logic [ADDR_W-1:0] base;
        logic [SP_W-1:0]   sp;
    } ctxr_op_t;

    // Descriptor address for task tn: base + 2*tn, wrapping in the address space.
    function automatic logic [ADDR_W-1:0] tbl_entry(input logic [ADDR_W-1:0] base,
                                                    input logic [BYTE_W-1:0] tn);
        return base + ADDR_W'({tn, 1'b0});
    endfunction
endpackage

// File: rtl/ctxr_pick.sv
module ctxr_pick #(
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Lowest set bit wins: scan from the top so the last hit is the lowest.
    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/ctxr_stack_rd.sv
module ctxr_stack_rd #(
    parameter int PW = 16,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [PW-1:0] base_sp,
    input  logic          adv,
    input  logic          cap_lo,
    input  logic [BW-1:0] rdata,
    output logic [PW-1:0] ptr,
    output logic [2*BW-1:0] word
);
    logic [BW-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr  <= '0;
            lo_q <= '0;
        end else begin
            if (load)
                ptr <= base_sp;
            else if (adv)
                ptr <= ptr + PW'(1);
            if (cap_lo)
                lo_q <= rdata;
        end
    end

    assign word = {rdata, lo_q};
endmodule

// File: rtl/taskctx_restore.sv
module taskctx_restore
    import ctxr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [SP_W-1:0]   tnum_addr,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [SP_W-1:0]   sp_in,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              reg_we,
    output logic [IDX_W-1:0]  reg_sel,
    output logic [REG_W-1:0]  reg_wdata,
    output logic              sp_we,
    output logic [SP_W-1:0]   sp_wdata,
    output logic              busy,
    output logic              done
);
    ctxr_state_e       state;
    ctxr_op_t          op_q;
    logic [ADDR_W-1:0] entry_q;
    logic [NREG-1:0]   mask_q;
    logic [BYTE_W-1:0] corr_q;

    logic              mask_any;
    logic [IDX_W-1:0]  cur_idx;
    logic [NREG-1:0]   mask_rest;
    logic [SP_W-1:0]   ptr;
    logic [REG_W-1:0]  word;
    logic              ptr_load, ptr_adv, cap_lo;

    ctxr_pick #(.N(NREG)) u_pick (
        .vec (mask_q),
        .any (mask_any),
        .idx (cur_idx)
    );

    ctxr_stack_rd #(.PW(SP_W), .BW(BYTE_W)) u_stk (
        .clk     (clk),
        .rst     (rst),
        .load    (ptr_load),
        .base_sp (op_q.sp),
        .adv     (ptr_adv),
        .cap_lo  (cap_lo),
        .rdata   (mem_rdata),
        .ptr     (ptr),
        .word    (word)
    );

    assign mask_rest = mask_q & ~(NREG'(1) << cur_idx);
    assign ptr_load  = (state == S_GOT_CORR);
    assign ptr_adv   = (state == S_POP_LO) || (state == S_POP_HI);
    assign cap_lo    = (state == S_POP_HI);

    always_comb begin
        mem_rd_en = 1'b0;
        mem_addr  = '0;
        reg_we    = 1'b0;
        reg_sel   = cur_idx;
        reg_wdata = word;
        sp_we     = 1'b0;
        sp_wdata  = op_q.sp + SP_W'(corr_q);
        done      = 1'b0;
        busy      = (state != S_IDLE);
        unique case (state)
            S_RD_TN: begin
                mem_rd_en = 1'b1;
                mem_addr  = ADDR_W'(op_q.tnum_addr);
            end
            S_RD_MASK: begin
                mem_rd_en = 1'b1;
                mem_addr  = tbl_entry(op_q.base, mem_rdata);
            end
            S_RD_CORR: begin
                mem_rd_en = 1'b1;
                mem_addr  = entry_q + ADDR_W'(1);
            end
            S_POP_LO, S_POP_HI: begin
                mem_rd_en = 1'b1;
                mem_addr  = ADDR_W'(ptr);
            end
            S_POP_END: reg_we = 1'b1;
            S_FIX: begin
                sp_we = 1'b1;
                done  = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            op_q    <= '0;
            entry_q <= '0;
            mask_q  <= '0;
            corr_q  <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        op_q.tnum_addr <= tnum_addr;
                        op_q.base      <= tbl_base;
                        op_q.sp        <= sp_in;
                        state          <= S_RD_TN;
                    end
                end
                S_RD_TN:   state <= S_RD_MASK;
                S_RD_MASK: begin
                    entry_q <= mem_addr;
                    state   <= S_RD_CORR;
                end
                S_RD_CORR: begin
                    mask_q <= mem_rdata;
                    state  <= S_GOT_CORR;
                end
                S_GOT_CORR: begin
                    corr_q <= mem_rdata;
                    state  <= mask_any ? S_POP_LO : S_FIX;
                end
                S_POP_LO:  state <= S_POP_HI;
                S_POP_HI:  state <= S_POP_END;
                S_POP_END: begin
                    mask_q <= mask_rest;
                    state  <= (mask_rest == '0) ? S_FIX : S_POP_LO;
                end
                S_FIX:     state <= S_IDLE;
                default:   state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/taskctx_restore_chk.sv
module taskctx_restore_chk
    import ctxr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             reg_we,
    input logic [IDX_W-1:0] reg_sel,
    input logic             sp_we,
    input logic             mem_rd_en
);
    logic             seen_q;
    logic [IDX_W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst || done) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (reg_we) begin
            seen_q <= 1'b1;
            last_q <= reg_sel;
        end
    end

    AST_SEL_ASCEND: assert property (@(posedge clk) disable iff (rst)
        (reg_we && seen_q) |-> (reg_sel > last_q)); // R4
    AST_DONE_SP: assert property (@(posedge clk) disable iff (rst)
        done |-> sp_we); // R6
    AST_SP_NOT_REG: assert property (@(posedge clk) disable iff (rst)
        !(sp_we && reg_we)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(mem_rd_en || reg_we || sp_we)); // R8
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy); // R9
endmodule

bind taskctx_restore taskctx_restore_chk u_chk (.*);

// File: tb/taskctx_restore_test.sv
module taskctx_restore_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] tnum_addr = '0;
    logic [19:0] tbl_base = '0;
    logic [15:0] sp_in = '0;
    logic        mem_rd_en;
    logic [19:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic        reg_we;
    logic [2:0]  reg_sel;
    logic [15:0] reg_wdata;
    logic        sp_we;
    logic [15:0] sp_wdata;
    logic        busy;
    logic        done;

    int total = 0;
    int fails = 0;

    logic [7:0] mem [logic [19:0]];

    always #2 clk = ~clk;

    taskctx_restore uut (.*);

    function automatic logic [7:0] rd(input logic [19:0] a);
        logic [19:0] t;
        if (mem.exists(a)) return mem[a];
        t = (a * 20'd37) ^ (a >> 5);
        return t[7:0] ^ 8'h5A;
    endfunction

    always @(posedge clk) if (mem_rd_en) mem_rdata <= rd(mem_addr);

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [15:0] ta, input logic [19:0] base,
                          input logic [15:0] sp, input logic [7:0] tn,
                          input logic [7:0] mask, input logic [7:0] corr,
                          input bit restart);
        logic [19:0] ent;
        logic [2:0]  got_sel [8];
        logic [15:0] got_dat [8];
        int ngot = 0;
        int lat = 0;
        int k = 0;
        logic [15:0] ptr;
        logic [15:0] fin_sp = '0;
        bit fin_we = 0;
        bit ok_addr = 1;
        mem.delete();
        ent = base + {11'd0, tn, 1'b0};
        mem[{4'h0, ta}] = tn;
        mem[ent] = mask;
        mem[ent + 20'd1] = corr;
        @(negedge clk);
        start = 1'b1; tnum_addr = ta; tbl_base = base; sp_in = sp;
        for (int c = 1; c <= 60; c++) begin
            @(negedge clk);
            start = 1'b0;
            if (c == 1) chk(mem_rd_en && mem_addr == {4'h0, ta}, "R2", "tnum read addr", mem_addr, {4'h0, ta});
            if (c == 2) chk(mem_rd_en && mem_addr == ent, "R3", "mask read addr", mem_addr, ent);
            if (c == 3) chk(mem_rd_en && mem_addr == ent + 20'd1, "R3", "corr read addr", mem_addr, ent + 20'd1);
            if (restart && c == 3) begin
                start = 1'b1; tnum_addr = ta ^ 16'h0F0F; tbl_base = base ^ 20'h00F00; sp_in = ~sp;
            end
            if (restart && c == 4) begin
                start = 1'b0;
                if (!busy) ok_addr = 0;
            end
            if (reg_we && ngot < 8) begin
                got_sel[ngot] = reg_sel; got_dat[ngot] = reg_wdata; ngot++;
            end
            if (done) begin
                lat = c; fin_we = sp_we; fin_sp = sp_wdata;
                break;
            end
        end
        if (restart) chk(ok_addr, "R9", "busy held after ignored start", 0, 1);
        for (int i = 0; i < 8; i++) if (mask[i]) k++;
        chk(lat == 5 + 3 * k, "R10", "done latency", lat, 5 + 3 * k);
        chk(ngot == k, mask == 0 ? "R7" : "R4", "register write count", ngot, k);
        ptr = sp;
        begin
            int j = 0;
            for (int i = 0; i < 8; i++) begin
                if (mask[i]) begin
                    logic [15:0] exp_w;
                    exp_w = {rd({4'h0, ptr + 16'd1}), rd({4'h0, ptr})};
                    if (j < ngot) begin
                        chk(got_sel[j] == 3'(i), "R4", "register index", got_sel[j], i);
                        chk(got_dat[j] == exp_w, "R5", "register data", got_dat[j], exp_w);
                    end
                    ptr = ptr + 16'd2;
                    j++;
                end
            end
        end
        chk(fin_we, "R6", "sp_we with done", fin_we, 1);
        chk(fin_sp == sp + {8'd0, corr}, "R6", "corrected sp", fin_sp, sp + {8'd0, corr});
        @(negedge clk);
        chk(!done && !busy, "R8", "done one cycle then idle", {done, busy}, 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!mem_rd_en && !reg_we && !sp_we && !busy, restart ? "R9" : "R8",
                "quiet after done", {mem_rd_en, reg_we, sp_we, busy}, 0);
        end
    endtask

    initial begin
        #(4 * 150000);
        fails++; total++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_rd_en && !reg_we && !sp_we, "R1", "outputs in reset",
            {busy, done, mem_rd_en, reg_we, sp_we}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !mem_rd_en && !reg_we && !sp_we, "R1", "outputs after reset",
            {busy, done, mem_rd_en, reg_we, sp_we}, 0);
        // Zero mask: only the stack correction (R7)
        run_op(16'h0100, 20'h30000, 16'h2000, 8'd3, 8'h00, 8'h05, 0);
        // Full mask across the 16-bit stack wrap (R5)
        run_op(16'h0200, 20'h40000, 16'hFFFA, 8'd9, 8'hFF, 8'h10, 0);
        // Task 255 with table address wrap (R3)
        run_op(16'h1234, 20'hFFF00, 16'h0800, 8'd255, 8'h81, 8'h04, 0);
        // Single highest and single lowest register (R4)
        run_op(16'h0300, 20'h50000, 16'h7000, 8'd0, 8'h80, 8'h02, 0);
        run_op(16'h0301, 20'h50010, 16'hFFFF, 8'd1, 8'h01, 8'hFE, 0);
        // Start while busy (R9)
        run_op(16'h0400, 20'h60000, 16'h1000, 8'd17, 8'h05, 8'h04, 1);
        for (int n = 0; n < 30; n++) begin
            logic [15:0] ta, sp;
            logic [19:0] base, ent;
            logic [7:0]  tn, mask, corr;
            ta   = 16'($urandom);
            base = 20'($urandom);
            sp   = 16'($urandom);
            tn   = 8'($urandom);
            mask = 8'($urandom);
            corr = 8'($urandom);
            ent  = base + {11'd0, tn, 1'b0};
            while ({4'h0, ta} == ent || {4'h0, ta} == ent + 20'd1) ta = ta + 16'd7;
            run_op(ta, base, sp, tn, mask, corr, n % 7 == 3);
        end
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule